// File: doc/BRIEF.md
# CFB Stream Chaining Controller

This block runs cipher feedback chaining over a stream of 128-bit blocks around an external 128-bit block cipher. Software or a DMA engine feeds each block as four 32-bit words through a write port. Results leave as four 32-bit words through a read port. The controller keeps the feedback register, which is seeded with an initialization vector when a stream starts. It hands the feedback value to the cipher through a request/done handshake and XORs the returned keystream with the buffered input block.

In encrypt mode the resulting ciphertext becomes the next feedback value. In decrypt mode the received ciphertext block becomes the next feedback value. Either way, the keystream of every block after the first depends on the data, and a stream of any length chains with no reload by software.

Progress is reported in two ways. A two-bit interrupt index code is meant for interrupt-driven software. A pair of one-cycle trigger pulses, one for input words and one for output words, is meant for a DMA engine that moves one word per pulse.

Top module: `cfb_chain_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no start, `irq_idx_o` is 0, `cipher_req_o` is 0 and both trigger outputs are 0.
- R2: A `start_i` pulse loads `iv_i` into the feedback register. One cycle later `irq_idx_o` reads 2 (input ready), `dma_in_trig_o` pulses and `cipher_in_o` equals the loaded vector.
- R3: Words are packed little-endian. The first word written fills bits [31:0] and the fourth fills bits [127:96]. The first word read returns bits [31:0] of the result and the fourth returns bits [127:96].
- R4: After the fourth accepted write, `cipher_req_o` rises and stays high, with `cipher_in_o` stable, until `cipher_done_i`. Writes made while input is not ready are ignored.
- R5: One cycle after `cipher_done_i` is sampled during a request, `irq_idx_o` reads 1 (output ready), `dma_out_trig_o` pulses, and the result equals `cipher_out_i` XOR the input block.
- R6: In encrypt mode (`decrypt_i` = 0), the cipher input for each block after the first is the previous result block (the ciphertext).
- R7: In decrypt mode (`decrypt_i` = 1), the cipher input for each block after the first is the previous input block (the ciphertext), and the results are the plaintext.
- R8: Input ready returns only after all four result words are read. `irq_idx_o` reads 0 while the cipher is busy. When both conditions are pending, output ready (1) takes priority over input ready (2).
- R9: `dma_in_trig_o` pulses once for each input word needed and `dma_out_trig_o` pulses once for each result word available. Each pulse is one cycle long and asks for exactly one 32-bit transfer.
- R10: Reads made while no result is pending are ignored and do not advance the read word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | One-cycle pulse: load IV, clear word positions, open input |
| decrypt_i | input | 1 | 1 = decrypt chaining, 0 = encrypt chaining |
| iv_i | input | 128 | Initialization vector sampled on start |
| wr_en_i | input | 1 | Write strobe for one input word |
| wr_data_i | input | 32 | Input word |
| rd_en_i | input | 1 | Read strobe that consumes one result word |
| rd_data_o | output | 32 | Current result word |
| cipher_req_o | output | 1 | Request to the block cipher, held until done |
| cipher_in_o | output | 128 | Feedback value presented to the cipher |
| cipher_done_i | input | 1 | Cipher finished; `cipher_out_i` valid |
| cipher_out_i | input | 128 | Keystream block from the cipher |
| irq_idx_o | output | 2 | 0 none, 1 output ready, 2 input ready |
| dma_in_trig_o | output | 1 | Pulse requesting one input word |
| dma_out_trig_o | output | 1 | Pulse offering one result word |

## Verification
The index code and the trigger pulses are registered, so each is due exactly one clock after the edge that samples its cause. The causes are a start, an accepted write, the done strobe and an accepted read. `cipher_req_o` rises one clock after the fourth write, and `rd_data_o` follows the read position combinationally. The bench drives every strobe on the falling edge and checks on the next falling edge, so it observes the state left by exactly one rising edge. Keystreams and expected blocks come from a bench-side cipher function and a bench-side feedback model. The bench checks the chaining, the packing order, the ignored accesses and each per-word trigger at the cycle where it falls due.

// File: rtl/cfb_chain_pkg.sv
package cfb_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_CIPH  = 2'd2,
    ST_DRAIN = 2'd3
  } cfb_state_e;

  localparam int IDX_W = 2;
  localparam logic [IDX_W-1:0] IDX_NONE = 2'd0;
  localparam logic [IDX_W-1:0] IDX_OUT  = 2'd1;
  localparam logic [IDX_W-1:0] IDX_IN   = 2'd2;
endpackage

// File: rtl/cfb_word_collect.sv
module cfb_word_collect #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [WORD_W-1:0]        data_i,
  output logic [WORD_W*WORDS-1:0]  blk_o,
  output logic                     last_o
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (wr_i) cnt_d = last_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    logic              w_en;
    assign w_en = wr_i && !clr_i && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= data_i;
    end
    assign blk_o[g*WORD_W +: WORD_W] = w_q;
  end
endmodule

// File: rtl/cfb_word_emit.sv
module cfb_word_emit #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [WORD_W*WORDS-1:0]  blk_i,
  input  logic                     rd_i,
  output logic [WORD_W-1:0]        data_o,
  output logic                     last_o
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [BLK_W-1:0] blk_q, blk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == LAST);
  assign data_o = blk_q[cnt_q*WORD_W +: WORD_W];

  always_comb begin
    blk_d = blk_q;
    cnt_d = cnt_q;
    if (load_i) begin
      blk_d = blk_i;
      cnt_d = '0;
    end else if (rd_i) begin
      cnt_d = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      cnt_q <= '0;
    end else begin
      blk_q <= blk_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cfb_seq.sv
module cfb_seq
  import cfb_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_en_i,
  input  logic             in_last_i,
  input  logic             rd_en_i,
  input  logic             out_last_i,
  input  logic             done_i,
  output logic             wr_acc_o,
  output logic             rd_acc_o,
  output logic             load_o,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             dma_in_o,
  output logic             dma_out_o
);
  cfb_state_e st_q, st_d;
  logic       din_q, din_d, dout_q, dout_d;
  logic       in_rdy, out_vld;

  assign in_rdy   = (st_q == ST_FILL);
  assign out_vld  = (st_q == ST_DRAIN);
  assign req_o    = (st_q == ST_CIPH);
  assign wr_acc_o = wr_en_i && in_rdy && !start_i;
  assign rd_acc_o = rd_en_i && out_vld && !start_i;
  assign load_o   = req_o && done_i && !start_i;

  always_comb begin
    st_d = st_q;
    if (start_i)                       st_d = ST_FILL;
    else if (wr_acc_o && in_last_i)    st_d = ST_CIPH;
    else if (load_o)                   st_d = ST_DRAIN;
    else if (rd_acc_o && out_last_i)   st_d = ST_FILL;
  end

  always_comb begin
    din_d  = start_i || (wr_acc_o && !in_last_i) || (rd_acc_o && out_last_i);
    dout_d = load_o || (rd_acc_o && !out_last_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      din_q  <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      din_q  <= din_d;
      dout_q <= dout_d;
    end
  end

  assign dma_in_o  = din_q;
  assign dma_out_o = dout_q;

  always_comb begin
    if (out_vld)     idx_o = IDX_OUT;
    else if (in_rdy) idx_o = IDX_IN;
    else             idx_o = IDX_NONE;
  end
endmodule

// File: rtl/cfb_chain_ctrl.sv
module cfb_chain_ctrl
  import cfb_chain_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     decrypt_i,
  input  logic [WORD_W*WORDS-1:0]  iv_i,
  input  logic                     wr_en_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  input  logic                     rd_en_i,
  output logic [WORD_W-1:0]        rd_data_o,
  output logic                     cipher_req_o,
  output logic [WORD_W*WORDS-1:0]  cipher_in_o,
  input  logic                     cipher_done_i,
  input  logic [WORD_W*WORDS-1:0]  cipher_out_i,
  output logic [IDX_W-1:0]         irq_idx_o,
  output logic                     dma_in_trig_o,
  output logic                     dma_out_trig_o
);
  localparam int BLK_W = WORD_W * WORDS;

  logic             wr_acc, rd_acc, load, in_last, out_last;
  logic [BLK_W-1:0] in_blk, res_blk, fb_q, fb_d;

  cfb_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wr_en_i    (wr_en_i),
    .in_last_i  (in_last),
    .rd_en_i    (rd_en_i),
    .out_last_i (out_last),
    .done_i     (cipher_done_i),
    .wr_acc_o   (wr_acc),
    .rd_acc_o   (rd_acc),
    .load_o     (load),
    .req_o      (cipher_req_o),
    .idx_o      (irq_idx_o),
    .dma_in_o   (dma_in_trig_o),
    .dma_out_o  (dma_out_trig_o)
  );

  cfb_word_collect #(.WORD_W(WORD_W), .WORDS(WORDS)) u_collect (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .wr_i   (wr_acc),
    .data_i (wr_data_i),
    .blk_o  (in_blk),
    .last_o (in_last)
  );

  assign res_blk = cipher_out_i ^ in_blk;

  cfb_word_emit #(.WORD_W(WORD_W), .WORDS(WORDS)) u_emit (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .blk_i  (res_blk),
    .rd_i   (rd_acc),
    .data_o (rd_data_o),
    .last_o (out_last)
  );

  // feedback: ciphertext of the block just processed, whichever side it sits on
  always_comb begin
    fb_d = fb_q;
    if (start_i)   fb_d = iv_i;
    else if (load) fb_d = decrypt_i ? in_blk : res_blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= '0;
    else        fb_q <= fb_d;
  end

  assign cipher_in_o = fb_q;
endmodule

// File: rtl/cfb_chain_chk.sv
module cfb_chain_chk #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [BLK_W-1:0] iv_i,
  input logic             cipher_req_o,
  input logic             cipher_done_i,
  input logic [BLK_W-1:0] cipher_in_o,
  input logic [1:0]       irq_idx_o,
  input logic             dma_in_trig_o,
  input logic             dma_out_trig_o
);
  assert_start_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (irq_idx_o == 2'd2) && dma_in_trig_o && (cipher_in_o == $past(iv_i)));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_req_o && !cipher_done_i && !start_i |=> cipher_req_o && $stable(cipher_in_o));

  assert_done_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_req_o && cipher_done_i && !start_i |=> (irq_idx_o == 2'd1) && dma_out_trig_o);

  assert_busy_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_req_o |-> (irq_idx_o == 2'd0));

  assert_idx_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_idx_o != 2'd3);

  assert_trig_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_in_trig_o, dma_out_trig_o}));

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (irq_idx_o == 2'd0 && !cipher_req_o
                                     && !dma_in_trig_o && !dma_out_trig_o);
    end
  end
endmodule

bind cfb_chain_ctrl cfb_chain_chk #(.BLK_W(WORD_W*WORDS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .iv_i           (iv_i),
  .cipher_req_o   (cipher_req_o),
  .cipher_done_i  (cipher_done_i),
  .cipher_in_o    (cipher_in_o),
  .irq_idx_o      (irq_idx_o),
  .dma_in_trig_o  (dma_in_trig_o),
  .dma_out_trig_o (dma_out_trig_o)
);

// File: tb/cfb_chain_ctrl_tb.sv
`timescale 1ns/1ps
module cfb_chain_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, decrypt_i = 1'b0;
  logic [127:0] iv_i = '0;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0]  wr_data_i = '0;
  logic [31:0]  rd_data_o;
  logic         cipher_req_o, cipher_done_i = 1'b0;
  logic [127:0] cipher_in_o, cipher_out_i = '0;
  logic [1:0]   irq_idx_o;
  logic         dma_in_trig_o, dma_out_trig_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [127:0] fb_m;
  logic [127:0] pt [3];
  logic [127:0] ct [3];

  always #2.5 clk = ~clk;

  cfb_chain_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i), .iv_i(iv_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .cipher_req_o(cipher_req_o), .cipher_in_o(cipher_in_o), .cipher_done_i(cipher_done_i),
    .cipher_out_i(cipher_out_i), .irq_idx_o(irq_idx_o), .dma_in_trig_o(dma_in_trig_o),
    .dma_out_trig_o(dma_out_trig_o));

  function automatic logic [127:0] ks_of(input logic [127:0] x);
    return {x[94:0], x[127:95]} ^ 128'h5A3C_96E1_0F0F_1234_C3A5_7E81_DEAD_0BEE;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk(irq_idx_o == 0 && !cipher_req_o && !dma_in_trig_o && !dma_out_trig_o,
        "R1 in reset", {irq_idx_o, cipher_req_o, dma_in_trig_o, dma_out_trig_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq_idx_o == 0 && !cipher_req_o && !dma_in_trig_o && !dma_out_trig_o,
        "R1 after reset", {irq_idx_o, cipher_req_o, dma_in_trig_o, dma_out_trig_o}, 0);
  endtask

  task automatic t_start(input logic [127:0] iv, input bit dec);
    iv_i = iv; decrypt_i = dec; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(irq_idx_o == 2, "R2 idx input ready", irq_idx_o, 2);
    chk(dma_in_trig_o, "R2 input trigger", dma_in_trig_o, 1);
    chk(cipher_in_o == iv, "R2 iv loaded", cipher_in_o, iv);
    fb_m = iv;
    @(negedge clk);
    chk(!dma_in_trig_o, "R9 trigger one cycle", dma_in_trig_o, 0);
  endtask

  task automatic run_block(input logic [127:0] blk, input bit dec, input bit junk,
                           output logic [127:0] res);
    logic [127:0] exp;
    exp = ks_of(fb_m) ^ blk;
    if (junk) begin
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
      chk(irq_idx_o == 2 && !dma_out_trig_o, "R10 stray read ignored",
          {irq_idx_o, dma_out_trig_o}, {2'd2, 1'b0});
    end
    for (int k = 0; k < 4; k++) begin
      wr_en_i = 1'b1; wr_data_i = blk[32*k +: 32];
      @(negedge clk);
      chk(dma_in_trig_o == (k != 3), "R9 input trigger per word", dma_in_trig_o, (k != 3));
    end
    wr_en_i = 1'b0;
    chk(cipher_req_o, "R4 request after fourth word", cipher_req_o, 1);
    chk(irq_idx_o == 0, "R8 idx none while busy", irq_idx_o, 0);
    chk(cipher_in_o == fb_m, dec ? "R7 decrypt feedback" : "R6 encrypt feedback", cipher_in_o, fb_m);
    if (junk) begin
      wr_en_i = 1'b1; wr_data_i = 32'hDEAD_BEEF;
      @(negedge clk);
      wr_en_i = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk(cipher_req_o && cipher_in_o == fb_m, "R4 request held stable", cipher_in_o, fb_m);
    cipher_out_i = ks_of(cipher_in_o); cipher_done_i = 1'b1;
    @(negedge clk);
    cipher_done_i = 1'b0; cipher_out_i = '0;
    chk(irq_idx_o == 1, "R5 idx output ready", irq_idx_o, 1);
    chk(dma_out_trig_o, "R5 output trigger", dma_out_trig_o, 1);
    chk(!cipher_req_o, "R5 request dropped", cipher_req_o, 0);
    if (junk) begin
      wr_en_i = 1'b1; wr_data_i = 32'h1111_2222;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk(irq_idx_o == 1 && !dma_in_trig_o, "R8 input held closed until drained",
          {irq_idx_o, dma_in_trig_o}, {2'd1, 1'b0});
    end
    for (int k = 0; k < 4; k++) begin
      chk(rd_data_o == exp[32*k +: 32], "R3 result word order", rd_data_o, exp[32*k +: 32]);
      rd_en_i = 1'b1;
      @(negedge clk);
      chk(dma_out_trig_o == (k != 3), "R9 output trigger per word", dma_out_trig_o, (k != 3));
    end
    rd_en_i = 1'b0;
    chk(irq_idx_o == 2 && dma_in_trig_o, "R8 input reopens after four reads",
        {irq_idx_o, dma_in_trig_o}, {2'd2, 1'b1});
    fb_m = dec ? blk : exp;
    res = exp;
  endtask

  task automatic t_encrypt;
    t_start(128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 1'b0);
    for (int i = 0; i < 3; i++) run_block(pt[i], 1'b0, 1'b0, ct[i]);
  endtask

  task automatic t_decrypt;
    logic [127:0] r;
    t_start(128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 1'b1);
    for (int i = 0; i < 3; i++) begin
      run_block(ct[i], 1'b1, (i == 1), r);
      chk(r == pt[i], "R7 decrypt recovers plaintext", r, pt[i]);
    end
  endtask

  task automatic t_ignored;
    logic [127:0] r;
    t_start(128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF, 1'b0);
    run_block(128'hCAFE_F00D_1234_5678_9ABC_DEF0_0BAD_BEEF, 1'b0, 1'b1, r);
    run_block(128'h8000_0000_0000_0001_FFFF_FFFF_0000_0000, 1'b0, 1'b1, r);
  endtask

  initial begin
    pt[0] = 128'h6BC1_BEE2_2E40_9F96_E93D_7E11_7393_172A;
    pt[1] = 128'hAE2D_8A57_1E03_AC9C_9EB7_6FAC_45AF_8E51;
    pt[2] = 128'h30C8_1C46_A35C_E411_E5FB_C119_1A0A_52EF;
    t_reset();
    t_encrypt();
    t_decrypt();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule